// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is a register-driven I2C bus master that builds a transfer out of single operations. Software enables the engine and writes a two-bit command to the control register. The command produces a START, a repeated START or a STOP condition on the bus. Writing the data register shifts one byte out, most significant bit first. On the ninth clock the block releases SDA and records whether the target acknowledged.

Each finished operation raises a session-done flag in a write-one-to-clear status register. A mask register selects which status bits drive the interrupt line. The bus lines are open-drain: the block only ever asserts an output enable that pulls a line low. A pad-control bit can float both lines regardless of what the engine is doing. The length of each SCL phase is a programmable count of system clock cycles, so one divider value serves both standard and fast bus rates.

The register map has six locations, selected by `reg_addr`:
- 0: control
- 1: data
- 2: status
- 3: mask
- 4: pad control
- 5: divider

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00, pad control reads 0x04 (bit 2 is the line-release bit) and neither bus line is pulled low.
- R2: While pad-control bit 2 is 1, `scl_oe` and `sda_oe` are both 0 whatever the engine state. Clearing the bit restores the levels the engine holds.
- R3: A control write with bit 0 = 1, bits [2:1] = 1 and bit 3 = 0 produces a START: SDA falls while SCL is high, then SCL is pulled low. Session-done (status bit 3) is then set.
- R4: The same write with bit 3 = 1 produces a repeated START, in this order: SDA is released while SCL is low, SCL is released, and SDA falls while SCL is high. Session-done is then set.
- R5: Control bits [2:1] = 2 with bit 0 = 1 produce a STOP: SDA is low while SCL rises, and SDA then rises while SCL is high. Both lines end released and session-done is set.
- R6: A data-register write with the engine enabled sends the eight bits MSB first. SDA changes only while SCL is low. A ninth clock follows with SDA released by the master.
- R7: The SDA level on the ninth clock is stored in control bit 3 (1 = NAK) and read back there. A NAK also sets status bit 0; an ACK leaves bit 0 clear.
- R8: Each completed byte sets session-done (status bit 3) and transmit-empty (status bit 1).
- R9: Status bit 7 (busy) reads 1 from the cycle after a launching write until the operation completes.
- R10: A control write with bits [2:1] = 0 or 3, or with bit 0 = 0, causes no bus activity and no status change. A data write while bit 0 is 0 also has no effect.
- R11: A control or data write while busy is ignored and sets status bit 2 (error).
- R12: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Bits 4, 5 and 6 read as 0.
- R13: `irq` is 1 exactly when some status bit and its matching mask bit are both 1.
- R14: Each SCL high phase of a data bit lasts the divider value in system clock cycles. A divider of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected location |
| irq | output | 1 | Masked status interrupt |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The hardest state to reach from the ports is a write that arrives while an operation is still running. The stimulus issues a data write and, on the very next register cycle, a START command. That second write lands inside the first bit of the byte, so it must be rejected and flagged as an error. The same byte is also answered with a NAK by the bench's target model, which pulls SDA low only after the eighth SCL rise and only when told to acknowledge. Separately, pad release is forced while the engine holds both lines low after a START, so that the release and the restore can be seen at the outputs.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [1:0] {
        OP_START   = 2'd0,
        OP_RESTART = 2'd1,
        OP_STOP    = 2'd2,
        OP_BYTE    = 2'd3
    } op_e;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_DATA = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_MASK = 3'd3;
    localparam logic [2:0] A_PAD  = 3'd4;
    localparam logic [2:0] A_DIV  = 3'd5;

    localparam logic [1:0] CMD_BEGIN = 2'd1;
    localparam logic [1:0] CMD_END   = 2'd2;

    localparam logic [3:0] ACK_BIT = 4'd8;

    typedef struct packed {
        logic scl_lo;
        logic sda_lo;
    } lines_t;

    // Final step index of a framing sequence.
    function automatic logic [1:0] last_step(op_e op);
        case (op)
            OP_START:   return 2'd1;
            OP_RESTART: return 2'd3;
            default:    return 2'd2;
        endcase
    endfunction

    // Line levels held during a step of a framing sequence.
    function automatic lines_t cmd_levels(op_e op, logic [1:0] step);
        lines_t r;
        r = '{scl_lo: 1'b0, sda_lo: 1'b0};
        case (op)
            OP_START: begin
                case (step)
                    2'd0:    r = '{scl_lo: 1'b0, sda_lo: 1'b1};
                    default: r = '{scl_lo: 1'b1, sda_lo: 1'b1};
                endcase
            end
            OP_RESTART: begin
                case (step)
                    2'd0:    r = '{scl_lo: 1'b1, sda_lo: 1'b0};
                    2'd1:    r = '{scl_lo: 1'b0, sda_lo: 1'b0};
                    2'd2:    r = '{scl_lo: 1'b0, sda_lo: 1'b1};
                    default: r = '{scl_lo: 1'b1, sda_lo: 1'b1};
                endcase
            end
            default: begin
                case (step)
                    2'd0:    r = '{scl_lo: 1'b1, sda_lo: 1'b1};
                    2'd1:    r = '{scl_lo: 1'b0, sda_lo: 1'b1};
                    default: r = '{scl_lo: 1'b0, sda_lo: 1'b0};
                endcase
            end
        endcase
        return r;
    endfunction

    // Line levels during phase ph (0 setup, 1 high, 2 hold) of bit bi.
    function automatic lines_t byte_levels(logic [7:0] b, logic [3:0] bi,
                                           logic [1:0] ph);
        lines_t r;
        logic [2:0] sel;
        sel      = 3'd7 - bi[2:0];
        r.scl_lo = (ph != 2'd1);
        r.sda_lo = (bi < ACK_BIT) ? ~b[sel] : 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] dmax;

    always_comb begin
        dmax = (div == '0) ? '0 : div - 1'b1;
        tick = run && (cnt == dmax);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  op_e        op,
    input  logic [7:0] byte_in,
    input  logic       tick,
    input  logic       sda_in,
    output logic       active,
    output logic       done,
    output logic       done_byte,
    output logic       nak,
    output lines_t     lines
);
    op_e        op_q;
    logic [1:0] step;
    logic [3:0] bitidx;
    logic [1:0] ph;
    logic [7:0] byte_q;
    logic       is_last;
    logic [3:0] nxt_bit;
    logic [1:0] nxt_ph;

    always_comb begin
        if (op_q == OP_BYTE) begin
            is_last = (bitidx == ACK_BIT) && (ph == 2'd2);
        end else begin
            is_last = (step == last_step(op_q));
        end
        done      = active && tick && is_last;
        done_byte = done && (op_q == OP_BYTE);
        nxt_ph    = (ph == 2'd2) ? 2'd0 : ph + 2'd1;
        nxt_bit   = (ph == 2'd2) ? bitidx + 4'd1 : bitidx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            op_q   <= OP_START;
            step   <= '0;
            bitidx <= '0;
            ph     <= '0;
            byte_q <= '0;
            nak    <= 1'b0;
            lines  <= '{scl_lo: 1'b0, sda_lo: 1'b0};
        end else if (go && !active) begin
            active <= 1'b1;
            op_q   <= op;
            step   <= '0;
            bitidx <= '0;
            ph     <= '0;
            byte_q <= byte_in;
            lines  <= (op == OP_BYTE) ? byte_levels(byte_in, 4'd0, 2'd0)
                                      : cmd_levels(op, 2'd0);
        end else if (active && tick) begin
            if (op_q == OP_BYTE && bitidx == ACK_BIT && ph == 2'd1) begin
                nak <= sda_in;
            end
            if (is_last) begin
                active <= 1'b0;
            end else if (op_q == OP_BYTE) begin
                ph     <= nxt_ph;
                bitidx <= nxt_bit;
                lines  <= byte_levels(byte_q, nxt_bit, nxt_ph);
            end else begin
                step  <= step + 2'd1;
                lines <= cmd_levels(op_q, step + 2'd1);
            end
        end
    end
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
    import i2cm_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int RESET_DIV = 63
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [2:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic             irq,
    input  logic             eng_active,
    input  logic             eng_done,
    input  logic             eng_done_byte,
    input  logic             eng_nak,
    output logic             go,
    output op_e              op,
    output logic [7:0]       tx_byte,
    output logic             pad_off,
    output logic [DIV_W-1:0] div,
    output logic [7:0]       stat_vec
);
    logic       ctrl_en, ctrl_qual, nak_flag;
    logic [1:0] ctrl_cmd;
    logic [7:0] data_q, mask_q;
    logic       st_noack, st_txe, st_err, st_done;
    logic       wr_ctrl, wr_data, wr_stat, rejected, launch_cmd, launch_byte;
    logic [7:0] clr;

    always_comb begin
        wr_ctrl     = we && (addr == A_CTRL);
        wr_data     = we && (addr == A_DATA);
        wr_stat     = we && (addr == A_STAT);
        rejected    = (wr_ctrl || wr_data) && eng_active;
        launch_cmd  = wr_ctrl && !eng_active && wdata[0] &&
                      (wdata[2:1] == CMD_BEGIN || wdata[2:1] == CMD_END);
        launch_byte = wr_data && !eng_active && ctrl_en;
        go          = launch_cmd || launch_byte;
        if (launch_byte)                 op = OP_BYTE;
        else if (wdata[2:1] == CMD_END)  op = OP_STOP;
        else if (wdata[3])               op = OP_RESTART;
        else                             op = OP_START;
        tx_byte  = wdata;
        clr      = wr_stat ? wdata : 8'h00;
        stat_vec = {eng_active, 3'b000, st_done, st_err, st_txe, st_noack};
        irq      = |(stat_vec & mask_q);
        case (addr)
            A_CTRL:  rdata = {4'b0000, nak_flag, ctrl_cmd, ctrl_en};
            A_DATA:  rdata = data_q;
            A_STAT:  rdata = stat_vec;
            A_MASK:  rdata = mask_q;
            A_PAD:   rdata = {5'b00000, pad_off, 2'b00};
            A_DIV:   rdata = 8'(div);
            default: rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en   <= 1'b0;
            ctrl_cmd  <= 2'd0;
            ctrl_qual <= 1'b0;
            nak_flag  <= 1'b0;
            data_q    <= '0;
            mask_q    <= '0;
            pad_off   <= 1'b1;
            div       <= DIV_W'(RESET_DIV);
            st_noack  <= 1'b0;
            st_txe    <= 1'b0;
            st_err    <= 1'b0;
            st_done   <= 1'b0;
        end else begin
            if (wr_ctrl && !eng_active) begin
                ctrl_en   <= wdata[0];
                ctrl_cmd  <= wdata[2:1];
                ctrl_qual <= wdata[3];
            end
            if (wr_data && !eng_active) data_q <= wdata;
            if (we && addr == A_MASK)   mask_q <= wdata;
            if (we && addr == A_PAD)    pad_off <= wdata[2];
            if (we && addr == A_DIV)    div <= wdata[DIV_W-1:0];
            if (eng_done_byte)          nak_flag <= eng_nak;
            st_noack <= (st_noack & ~clr[0]) | (eng_done_byte & eng_nak);
            st_txe   <= (st_txe   & ~clr[1]) | eng_done_byte;
            st_err   <= (st_err   & ~clr[2]) | rejected;
            st_done  <= (st_done  & ~clr[3]) | eng_done;
        end
    end

    logic unused_qual;
    assign unused_qual = ctrl_qual;
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int RESET_DIV = 63
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_we,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       sda_in
);
    logic             go, tick, eng_active, eng_done, eng_done_byte, eng_nak;
    logic             pad_off;
    op_e              op;
    logic [7:0]       tx_byte, stat_vec;
    logic [DIV_W-1:0] div;
    lines_t           lines;

    i2cm_regs #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .irq(irq), .eng_active(eng_active),
        .eng_done(eng_done), .eng_done_byte(eng_done_byte), .eng_nak(eng_nak),
        .go(go), .op(op), .tx_byte(tx_byte), .pad_off(pad_off), .div(div),
        .stat_vec(stat_vec)
    );

    i2cm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .run(eng_active), .clear(go), .div(div),
        .tick(tick)
    );

    i2cm_seq u_seq (
        .clk(clk), .rst(rst), .go(go), .op(op), .byte_in(tx_byte),
        .tick(tick), .sda_in(sda_in), .active(eng_active), .done(eng_done),
        .done_byte(eng_done_byte), .nak(eng_nak), .lines(lines)
    );

    assign scl_oe = lines.scl_lo & ~pad_off;
    assign sda_oe = lines.sda_lo & ~pad_off;
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk
    import i2cm_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       we,
    input logic [2:0] addr,
    input logic [7:0] wdata,
    input logic       go,
    input logic       active,
    input logic       done,
    input logic       scl_lo,
    input logic       sda_lo,
    input op_e        op_q,
    input logic [7:0] stat
);
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !$past(active)) |-> ($stable(scl_lo) && $stable(sda_lo)));

    // R6
    sda_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!scl_lo && !$past(scl_lo) && (sda_lo != $past(sda_lo)))
            |-> (op_q != OP_BYTE));

    // R8
    sdone_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> stat[3]);

    // R9
    busy_chk: assert property (@(posedge clk) disable iff (rst)
        go |=> stat[7]);

    // R11
    err_chk: assert property (@(posedge clk) disable iff (rst)
        (we && (addr == A_CTRL || addr == A_DATA) && active) |=> stat[2]);

    // R12
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_STAT && wdata[3] && !done) |=> !stat[3]);
endmodule

bind i2c_byte_master i2cm_chk u_chk (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .go(go), .active(eng_active), .done(eng_done), .scl_lo(lines.scl_lo),
    .sda_lo(lines.sda_lo), .op_q(u_seq.op_q), .stat(stat_vec)
);

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;
    import i2cm_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       we = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq, scl_oe, sda_oe;
    logic       slave_low = 1'b0;
    logic       sda_in;

    always #4 clk = ~clk;
    assign sda_in = ~(sda_oe | slave_low);

    i2c_byte_master u0 (
        .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .sda_in(sda_in)
    );

    int   n_chk = 0;
    int   n_bad = 0;
    int   exp_q[$];
    logic ack_mode = 1'b1;
    logic ack_seen = 1'b1;
    int   hi_run = 0;
    int   last_hi = 0;

    task automatic check(string req, int act, int expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Scoreboard pop: 0x100 START, 0x200 STOP, otherwise a byte (R3 R4 R5 R6)
    task automatic sb_event(int v);
        if (exp_q.size() == 0) begin
            check("R6 unexpected bus event", v, -1);
        end else begin
            check("R6 bus event", v, exp_q.pop_front());
        end
    endtask

    // Bus monitor and target model
    logic       pscl = 1'b1, psda = 1'b1;
    int         bitcnt = 0;
    logic [7:0] sh = '0;
    always @(negedge clk) begin
        logic scl, sda;
        scl = ~scl_oe;
        sda = sda_in;
        if (!rst) begin
            if (scl && pscl && psda && !sda) begin
                sb_event(32'h100);
                bitcnt = 0;
            end else if (scl && pscl && !psda && sda) begin
                sb_event(32'h200);
                bitcnt = 0;
            end else if (scl && !pscl) begin
                if (bitcnt < 8) begin
                    sh = {sh[6:0], sda};
                    bitcnt++;
                    if (bitcnt == 8) sb_event(int'(sh));
                end else if (bitcnt == 8) begin
                    ack_seen = sda;
                    bitcnt   = 9;
                end
            end else if (!scl && pscl) begin
                last_hi = hi_run;
                if (bitcnt == 8) slave_low = ack_mode;
                else if (bitcnt == 9) begin
                    slave_low = 1'b0;
                    bitcnt    = 0;
                end
            end
            hi_run = scl ? hi_run + 1 : 0;
        end
        pscl = scl;
        psda = sda;
    end

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        we = 1'b0; addr = a;
        #1 v = rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        int guard = 0;
        do begin
            rd(A_STAT, v);
            guard++;
        end while (v[7] && guard < 5000);
    endtask

    task automatic send_byte(logic [7:0] b, logic ack);
        ack_mode = ack;
        exp_q.push_back(int'(b));
        wr(A_DATA, b);
        wait_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog expired", 1, 0);
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        rd(A_CTRL, v); check("R1 ctrl reset", v, 8'h00);
        rd(A_STAT, v); check("R1 stat reset", v, 8'h00);
        rd(A_PAD, v);  check("R1 pad reset", v, 8'h04);
        check("R1 lines released", {scl_oe, sda_oe}, 2'b00);

        wr(A_PAD, 8'h00);
        wr(A_DIV, 8'd4);

        // R10: no action commands
        wr(A_CTRL, 8'h01);
        repeat (30) @(negedge clk);
        wr(A_CTRL, 8'h07);
        repeat (30) @(negedge clk);
        wr(A_CTRL, 8'h02);
        wr(A_DATA, 8'h55);
        repeat (30) @(negedge clk);
        check("R10 lines idle", {scl_oe, sda_oe}, 2'b00);
        rd(A_STAT, v); check("R10 no status", v, 8'h00);

        // R3 START, R9 busy
        exp_q.push_back(32'h100);
        wr(A_CTRL, 8'h03);
        rd(A_STAT, v); check("R9 busy after launch", v[7], 1);
        wait_idle();
        rd(A_STAT, v); check("R3 session done", v, 8'h08);
        check("R3 both lines low", {scl_oe, sda_oe}, 2'b11);
        wr(A_STAT, 8'h08);
        rd(A_STAT, v); check("R12 w1c clear", v, 8'h00);
        wr(A_CTRL, 8'h01);

        // R6 R7 R8 R14: ACKed byte
        send_byte(8'hA5, 1'b1);
        rd(A_CTRL, v); check("R7 ack in ctrl", v, 8'h01);
        rd(A_STAT, v); check("R8 done and txe", v, 8'h0A);
        check("R7 ack seen on bus", ack_seen, 0);
        check("R14 high phase div4", last_hi, 4);
        wr(A_STAT, 8'h02);
        rd(A_STAT, v); check("R12 w1c keeps others", v, 8'h08);
        wr(A_STAT, 8'hFF);
        rd(A_STAT, v); check("R12 reserved zero", v, 8'h00);

        // R11 write while busy, R7 NAK
        ack_mode = 1'b0;
        exp_q.push_back(32'h3C);
        wr(A_DATA, 8'h3C);
        wr(A_CTRL, 8'h03);
        wait_idle();
        rd(A_CTRL, v); check("R7 nak in ctrl", v, 8'h09);
        rd(A_STAT, v); check("R11 error and R7 noack", v, 8'h0F);

        // R13 interrupt masking
        wr(A_MASK, 8'h20);
        check("R13 irq masked", irq, 0);
        wr(A_MASK, 8'h04);
        check("R13 irq on error", irq, 1);
        wr(A_STAT, 8'h04);
        check("R13 irq after clear", irq, 0);
        wr(A_STAT, 8'hFF);

        // R4 repeated START
        exp_q.push_back(32'h100);
        wr(A_CTRL, 8'h0B);
        wait_idle();
        rd(A_STAT, v); check("R4 session done", v, 8'h08);
        wr(A_STAT, 8'hFF);
        wr(A_CTRL, 8'h01);

        // R14 divider boundaries
        wr(A_DIV, 8'd1);
        send_byte(8'h81, 1'b1);
        check("R14 high phase div1", last_hi, 1);
        rd(A_CTRL, v); check("R7 ack after nak", v, 8'h01);
        wr(A_DIV, 8'd0);
        send_byte(8'h00, 1'b1);
        check("R14 high phase div0", last_hi, 1);
        wr(A_DIV, 8'd3);

        // R5 STOP
        exp_q.push_back(32'h200);
        wr(A_CTRL, 8'h05);
        wait_idle();
        rd(A_STAT, v); check("R5 session done", v[3], 1);
        check("R5 lines released", {scl_oe, sda_oe}, 2'b00);
        wr(A_STAT, 8'hFF);

        // R2 pad release while lines held low
        exp_q.push_back(32'h100);
        wr(A_CTRL, 8'h03);
        wait_idle();
        wr(A_PAD, 8'h04);
        check("R2 pad release", {scl_oe, sda_oe}, 2'b00);
        wr(A_PAD, 8'h00);
        check("R2 pad restore", {scl_oe, sda_oe}, 2'b11);
        exp_q.push_back(32'h200);
        wr(A_CTRL, 8'h05);
        wait_idle();

        repeat (10) @(negedge clk);
        check("R6 scoreboard drained", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule